// File: doc/BRIEF.md
# SD/MMC Card Bring-Up Sequencer

This block is a state machine that takes a freshly inserted memory card from power-up to the selected transfer state. It asks a clock generator for a slow identification rate and waits for the card to settle. It then issues the reset, interface-condition and operating-condition commands through a command-issue port. It tells SD cards from MMC cards and learns the capacity class. It obtains the card's relative address, captures the 128-bit identification and card-specific data registers, selects the card and finally requests the fast transfer clock.

The command-issue port presents a command index, a response kind and a 32-bit argument. It holds them until the bus engine returns a completion with an error flag and up to 128 response bits. Results (card type, capacity class, relative address, identification and card-specific data) are registered and stay valid while `done_o` is high. A failed run raises `fail_o` with a code naming the step that failed.

Top module: `sd_init_seq`

## Requirements
- R1: Out of reset no command or clock request is pending, `done_o`, `fail_o`, `fail_code_o`, `rca_o`, `is_mmc_o`, `is_hc_o` are zero and `clk_khz_o` is 0.
- R2: `start_i` (accepted when idle, done or failed) raises `clk_req_o` with `clk_khz_o`=400 until `clk_rdy_i`. No command is issued while a clock request is pending. At least SETTLE_CYC cycles after the acknowledge, index 0 is issued with kind 0 (no response) and argument 0.
- R3: Index 8 follows with kind 1 and argument 0xAA ORed with 0x100 when any of `volt_mask_i[23:15]` is set, else with 0x200. Response kinds: 0 none, 1 short, 2 long (136-bit), 3 short with busy.
- R4: Only an error-free index-8 response whose bits [31:0] equal the argument exactly sets bit 30 of the later operating-condition arguments. An index-8 error or a mismatch clears that bit and is not a failure.
- R5: The SD probe is index 55 then index 41, both with argument 0. If either returns an error, index 1 with argument 0 is tried and its success marks the card MMC. If both probes fail, the run fails with code 2.
- R6: Polling repeats the type's operating-condition command with argument {bit 30 from R4, bits [23:0] = `volt_mask_i`}: index 55 (argument 0) then 41 for SD, index 1 for MMC. It stops when response bit 31 is set, and consecutive polls are at least GAP_CYC cycles apart.
- R7: After POLL_MAX busy poll responses the run fails with code 4. An error on a poll command fails with code 3.
- R8: `is_hc_o` takes response bit 30 of the poll response that ended polling.
- R9: Index 2 (kind 2) stores the 128 response bits in `cid_o`. Index 3 (kind 1) follows with argument 0x00010000 and address 1 for MMC, or argument 0 and address taken from response bits [31:16] for SD.
- R10: Index 9 (kind 2) with argument {address,16'h0} stores `csd_o`. Index 7 (kind 3) with the same argument follows, then a clock request of 25000 kHz, and on its acknowledge `done_o` rises.
- R11: An error on index 0 fails with code 1, on index 2 with code 5, on index 3 with 6, on index 9 with 7 and on index 7 with 8.
- R12: `cmd_valid_o` stays high with index, kind and argument unchanged until a cycle with `cmd_done_i`. Each command is issued once per step.
- R13: `start_i` is ignored while a run is in progress. `done_o`/`fail_o` and the results hold until the next accepted start, and `done_o` and `fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up run |
| volt_mask_i | input | 24 | Supported-voltage window used in arguments |
| clk_req_o | output | 1 | Card clock rate change request |
| clk_khz_o | output | 16 | Requested card clock rate in kHz |
| clk_rdy_i | input | 1 | Clock generator reports the new rate is stable |
| cmd_valid_o | output | 1 | Command pending on the issue port |
| cmd_idx_o | output | 6 | Command index |
| cmd_rsp_o | output | 2 | Response kind (0 none, 1 short, 2 long, 3 short busy) |
| cmd_arg_o | output | 32 | Command argument |
| cmd_done_i | input | 1 | Command finished, response valid |
| cmd_err_i | input | 1 | Command finished with an error |
| cmd_rsp_data_i | input | 128 | Response bits; short responses in [31:0] |
| done_o | output | 1 | Card selected and fast clock running |
| fail_o | output | 1 | Run aborted |
| fail_code_o | output | 4 | Failing step code |
| is_mmc_o | output | 1 | Card answered the MMC probe |
| is_hc_o | output | 1 | Card reports high capacity |
| rca_o | output | 16 | Relative card address |
| cid_o | output | 128 | Captured identification register |
| csd_o | output | 128 | Captured card-specific data register |

## Verification
The assertions assume the bus engine raises `cmd_done_i` for one cycle only while `cmd_valid_o` is high, and that `clk_rdy_i` pulses only while `clk_req_o` is pending. They also assume `volt_mask_i` and `start_i` are quiet in the cycle a result is checked. The bench's card model answers each command once, a few cycles after it sees it, and pulses the clock acknowledge only in answer to a request. Its scenario settings choose which probes succeed, how long the card stays busy, what the interface-condition echo returns and which step reports an error.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_SHORT      = 2'd1,
    RSP_LONG       = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_kind_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CLK_LO, S_SETTLE, S_GO_IDLE, S_IF_COND,
    S_PROBE_APP, S_PROBE_SD, S_PROBE_MMC,
    S_POLL_APP, S_POLL_OP, S_POLL_GAP,
    S_CID, S_RCA, S_CSD, S_SELECT, S_CLK_HI,
    S_DONE, S_FAIL
  } seq_state_e;

  localparam logic [3:0] FC_NONE         = 4'd0;
  localparam logic [3:0] FC_GO_IDLE      = 4'd1;
  localparam logic [3:0] FC_NO_CARD      = 4'd2;
  localparam logic [3:0] FC_POLL_ERR     = 4'd3;
  localparam logic [3:0] FC_POLL_TIMEOUT = 4'd4;
  localparam logic [3:0] FC_CID          = 4'd5;
  localparam logic [3:0] FC_RCA          = 4'd6;
  localparam logic [3:0] FC_CSD          = 4'd7;
  localparam logic [3:0] FC_SELECT       = 4'd8;

  localparam logic [31:0] MMC_RCA_ARG = 32'h0001_0000;

  // voltage code depends on whether the window reaches the upper range
  function automatic logic [31:0] if_cond_arg(input logic [23:0] mask);
    logic [3:0] vcode;
    vcode = (|mask[23:15]) ? 4'h1 : 4'h2;
    return {20'h0, vcode, 8'hAA};
  endfunction

endpackage

// File: rtl/sd_delay.sv
module sd_delay #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  output logic         busy_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= count_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R6
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sd_cmd_port.sv
module sd_cmd_port
  import sd_init_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [5:0]   idx_i,
  input  rsp_kind_e    kind_i,
  input  logic [31:0]  arg_i,
  output logic         cmd_valid_o,
  output logic [5:0]   cmd_idx_o,
  output logic [1:0]   cmd_rsp_o,
  output logic [31:0]  cmd_arg_o,
  input  logic         cmd_done_i,
  input  logic         cmd_err_i,
  input  logic [127:0] rsp_data_i,
  output logic         cmp_o,
  output logic         err_o,
  output logic [127:0] rsp_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_idx_o   <= '0;
      cmd_rsp_o   <= '0;
      cmd_arg_o   <= '0;
      cmp_o       <= 1'b0;
      err_o       <= 1'b0;
      rsp_o       <= '0;
    end else begin
      cmp_o <= 1'b0;
      if (!cmd_valid_o) begin
        if (req_i) begin
          cmd_valid_o <= 1'b1;
          cmd_idx_o   <= idx_i;
          cmd_rsp_o   <= kind_i;
          cmd_arg_o   <= arg_i;
        end
      end else if (cmd_done_i) begin
        cmd_valid_o <= 1'b0;
        cmp_o       <= 1'b1;
        err_o       <= cmd_err_i;
        rsp_o       <= rsp_data_i;
      end
    end
  end

  // R12
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_done_i) |=>
      (cmd_valid_o && $stable(cmd_idx_o) && $stable(cmd_arg_o) && $stable(cmd_rsp_o)));

  // R12
  cmp_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_o |-> $past(cmd_valid_o));

endmodule

// File: rtl/sd_card_info.sv
module sd_card_info (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         type_we_i,
  input  logic         mmc_i,
  input  logic         hc_we_i,
  input  logic         hc_i,
  input  logic         rca_we_i,
  input  logic [15:0]  rca_i,
  input  logic         cid_we_i,
  input  logic         csd_we_i,
  input  logic [127:0] data_i,
  output logic         is_mmc_o,
  output logic         is_hc_o,
  output logic [15:0]  rca_o,
  output logic [127:0] cid_o,
  output logic [127:0] csd_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_mmc_o <= 1'b0;
      is_hc_o  <= 1'b0;
      rca_o    <= '0;
      cid_o    <= '0;
      csd_o    <= '0;
    end else if (clr_i) begin
      is_mmc_o <= 1'b0;
      is_hc_o  <= 1'b0;
      rca_o    <= '0;
      cid_o    <= '0;
      csd_o    <= '0;
    end else begin
      if (type_we_i) is_mmc_o <= mmc_i;
      if (hc_we_i)   is_hc_o  <= hc_i;
      if (rca_we_i)  rca_o    <= rca_i;
      if (cid_we_i)  cid_o    <= data_i;
      if (csd_we_i)  csd_o    <= data_i;
    end
  end

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sd_init_pkg::*;
#(
  parameter int SETTLE_CYC = 18500,
  parameter int GAP_CYC    = 500000,
  parameter int POLL_MAX   = 200,
  parameter int KHZ_W      = 16,
  parameter int LO_KHZ     = 400,
  parameter int HI_KHZ     = 25000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [23:0]      volt_mask_i,
  output logic             clk_req_o,
  output logic [KHZ_W-1:0] clk_khz_o,
  input  logic             clk_rdy_i,
  output logic             cmd_valid_o,
  output logic [5:0]       cmd_idx_o,
  output logic [1:0]       cmd_rsp_o,
  output logic [31:0]      cmd_arg_o,
  input  logic             cmd_done_i,
  input  logic             cmd_err_i,
  input  logic [127:0]     cmd_rsp_data_i,
  output logic             done_o,
  output logic             fail_o,
  output logic [3:0]       fail_code_o,
  output logic             is_mmc_o,
  output logic             is_hc_o,
  output logic [15:0]      rca_o,
  output logic [127:0]     cid_o,
  output logic [127:0]     csd_o
);

  localparam int TMR_MAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int TRY_W   = $clog2(POLL_MAX + 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_MAX - 1);

  seq_state_e       state_q;
  logic             issued_q;
  logic             hcs_q;
  logic [TRY_W-1:0] tries_q;

  logic             req;
  logic             is_cmd;
  logic [5:0]       idx;
  rsp_kind_e        kind;
  logic [31:0]      arg;
  logic [31:0]      cond_arg;
  logic [31:0]      op_arg;
  logic             cmp;
  logic             cerr;
  logic [127:0]     rsp;
  logic             ok;
  logic             start_ok;
  logic             tmr_load;
  logic             tmr_busy;
  logic [TMR_W-1:0] tmr_val;
  logic [15:0]      rca_new;

  assign cond_arg = if_cond_arg(volt_mask_i);
  assign op_arg   = {1'b0, hcs_q, 6'b0, volt_mask_i};
  assign ok       = cmp && !cerr;
  assign start_ok = start_i && (state_q == S_IDLE || state_q == S_DONE || state_q == S_FAIL);
  assign rca_new  = is_mmc_o ? 16'h0001 : rsp[31:16];

  always_comb begin
    is_cmd = 1'b1;
    idx    = 6'd0;
    kind   = RSP_SHORT;
    arg    = '0;
    unique case (state_q)
      S_GO_IDLE:               kind = RSP_NONE;
      S_IF_COND:   begin idx = 6'd8;  arg = cond_arg; end
      S_PROBE_APP,
      S_POLL_APP:              idx = 6'd55;
      S_PROBE_SD:              idx = 6'd41;
      S_PROBE_MMC:             idx = 6'd1;
      S_POLL_OP:   begin idx = is_mmc_o ? 6'd1 : 6'd41; arg = op_arg; end
      S_CID:       begin idx = 6'd2;  kind = RSP_LONG; end
      S_RCA:       begin idx = 6'd3;  arg = is_mmc_o ? MMC_RCA_ARG : 32'h0; end
      S_CSD:       begin idx = 6'd9;  kind = RSP_LONG; arg = {rca_o, 16'h0}; end
      S_SELECT:    begin idx = 6'd7;  kind = RSP_SHORT_BUSY; arg = {rca_o, 16'h0}; end
      default:                 is_cmd = 1'b0;
    endcase
  end

  assign req = is_cmd && !issued_q;

  assign tmr_load = (state_q == S_CLK_LO && clk_rdy_i) ||
                    (state_q == S_POLL_OP && ok && !rsp[31] && tries_q != TRY_LAST);
  assign tmr_val  = (state_q == S_CLK_LO) ? TMR_W'(SETTLE_CYC) : TMR_W'(GAP_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      issued_q    <= 1'b0;
      hcs_q       <= 1'b0;
      tries_q     <= '0;
      fail_code_o <= FC_NONE;
      clk_khz_o   <= '0;
    end else begin
      if (req) issued_q <= 1'b1;
      if (cmp) issued_q <= 1'b0;
      unique case (state_q)
        S_IDLE, S_DONE, S_FAIL:
          if (start_ok) begin
            state_q     <= S_CLK_LO;
            clk_khz_o   <= KHZ_W'(LO_KHZ);
            fail_code_o <= FC_NONE;
            hcs_q       <= 1'b0;
            tries_q     <= '0;
          end
        S_CLK_LO:  if (clk_rdy_i) state_q <= S_SETTLE;
        S_SETTLE:  if (!tmr_busy) state_q <= S_GO_IDLE;
        S_GO_IDLE:
          if (cmp) begin
            if (cerr) begin state_q <= S_FAIL; fail_code_o <= FC_GO_IDLE; end
            else state_q <= S_IF_COND;
          end
        S_IF_COND:
          if (cmp) begin
            hcs_q   <= !cerr && (rsp[31:0] == cond_arg);
            state_q <= S_PROBE_APP;
          end
        S_PROBE_APP: if (cmp) state_q <= cerr ? S_PROBE_MMC : S_PROBE_SD;
        S_PROBE_SD:  if (cmp) state_q <= cerr ? S_PROBE_MMC : S_POLL_APP;
        S_PROBE_MMC:
          if (cmp) begin
            if (cerr) begin state_q <= S_FAIL; fail_code_o <= FC_NO_CARD; end
            else state_q <= S_POLL_OP;
          end
        S_POLL_APP:
          if (cmp) begin
            if (cerr) begin state_q <= S_FAIL; fail_code_o <= FC_POLL_ERR; end
            else state_q <= S_POLL_OP;
          end
        S_POLL_OP:
          if (cmp) begin
            if (cerr) begin
              state_q <= S_FAIL; fail_code_o <= FC_POLL_ERR;
            end else if (rsp[31]) begin
              state_q <= S_CID;
            end else if (tries_q == TRY_LAST) begin
              state_q <= S_FAIL; fail_code_o <= FC_POLL_TIMEOUT;
            end else begin
              tries_q <= tries_q + 1'b1;
              state_q <= S_POLL_GAP;
            end
          end
        S_POLL_GAP: if (!tmr_busy) state_q <= is_mmc_o ? S_POLL_OP : S_POLL_APP;
        S_CID:
          if (cmp) begin
            if (cerr) begin state_q <= S_FAIL; fail_code_o <= FC_CID; end
            else state_q <= S_RCA;
          end
        S_RCA:
          if (cmp) begin
            if (cerr) begin state_q <= S_FAIL; fail_code_o <= FC_RCA; end
            else state_q <= S_CSD;
          end
        S_CSD:
          if (cmp) begin
            if (cerr) begin state_q <= S_FAIL; fail_code_o <= FC_CSD; end
            else state_q <= S_SELECT;
          end
        S_SELECT:
          if (cmp) begin
            if (cerr) begin
              state_q <= S_FAIL; fail_code_o <= FC_SELECT;
            end else begin
              state_q   <= S_CLK_HI;
              clk_khz_o <= KHZ_W'(HI_KHZ);
            end
          end
        S_CLK_HI: if (clk_rdy_i) state_q <= S_DONE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign clk_req_o = (state_q == S_CLK_LO) || (state_q == S_CLK_HI);
  assign done_o    = (state_q == S_DONE);
  assign fail_o    = (state_q == S_FAIL);

  sd_delay #(.W(TMR_W)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .count_i (tmr_val),
    .busy_o  (tmr_busy)
  );

  sd_cmd_port u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .idx_i       (idx),
    .kind_i      (kind),
    .arg_i       (arg),
    .cmd_valid_o (cmd_valid_o),
    .cmd_idx_o   (cmd_idx_o),
    .cmd_rsp_o   (cmd_rsp_o),
    .cmd_arg_o   (cmd_arg_o),
    .cmd_done_i  (cmd_done_i),
    .cmd_err_i   (cmd_err_i),
    .rsp_data_i  (cmd_rsp_data_i),
    .cmp_o       (cmp),
    .err_o       (cerr),
    .rsp_o       (rsp)
  );

  sd_card_info u_info (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .type_we_i ((state_q == S_PROBE_SD || state_q == S_PROBE_MMC) && ok),
    .mmc_i     (state_q == S_PROBE_MMC),
    .hc_we_i   (state_q == S_POLL_OP && ok && rsp[31]),
    .hc_i      (rsp[30]),
    .rca_we_i  (state_q == S_RCA && ok),
    .rca_i     (rca_new),
    .cid_we_i  (state_q == S_CID && ok),
    .csd_we_i  (state_q == S_CSD && ok),
    .data_i    (rsp),
    .is_mmc_o  (is_mmc_o),
    .is_hc_o   (is_hc_o),
    .rca_o     (rca_o),
    .cid_o     (cid_o),
    .csd_o     (csd_o)
  );

  // R2
  no_cmd_in_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && clk_req_o));

  // R10
  csd_arg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_idx_o == 6'd9) |-> (cmd_arg_o == {rca_o, 16'h0}));

  // R11
  fail_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fail_code_o != FC_NONE));

  // R13
  done_fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  // R13
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(rca_o) && $stable(cid_o) && $stable(csd_o)));

endmodule

// File: tb/tb_sd_init_seq.sv
`timescale 1ns/1ps
module tb_sd_init_seq;

  localparam int SETTLE = 16;
  localparam int GAP    = 12;
  localparam int PMAX   = 4;
  localparam logic [127:0] CID_PAT = 128'h0123_4567_89AB_CDEF_1122_3344_5566_7788;
  localparam logic [127:0] CSD_PAT = 128'hFEDC_BA98_7654_3210_A5A5_5A5A_0F0F_F0F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [23:0] volt_mask = 24'hFF8000;
  logic clk_req, clk_rdy = 1'b0;
  logic [15:0] clk_khz;
  logic cmd_valid;
  logic [5:0] cmd_idx;
  logic [1:0] cmd_rsp;
  logic [31:0] cmd_arg;
  logic cmd_done = 1'b0, cmd_err = 1'b0;
  logic [127:0] rsp_data = '0;
  logic done, fail, is_mmc, is_hc;
  logic [3:0] fail_code;
  logic [15:0] rca;
  logic [127:0] cid, csd;

  always #2.5 clk = ~clk;

  sd_init_seq #(.SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .POLL_MAX(PMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .volt_mask_i(volt_mask),
    .clk_req_o(clk_req), .clk_khz_o(clk_khz), .clk_rdy_i(clk_rdy),
    .cmd_valid_o(cmd_valid), .cmd_idx_o(cmd_idx), .cmd_rsp_o(cmd_rsp), .cmd_arg_o(cmd_arg),
    .cmd_done_i(cmd_done), .cmd_err_i(cmd_err), .cmd_rsp_data_i(rsp_data),
    .done_o(done), .fail_o(fail), .fail_code_o(fail_code), .is_mmc_o(is_mmc),
    .is_hc_o(is_hc), .rca_o(rca), .cid_o(cid), .csd_o(csd));

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // card model configuration
  bit cfg_cmd8_ok, cfg_echo_bad, cfg_sd_ok, cfg_mmc_ok, cfg_ccs;
  int cfg_busy, cfg_fail_idx;
  logic [15:0] cfg_rca;

  int n_cmd, n_clk, hold_bad, opn;
  logic [5:0]  log_idx [64];
  logic [31:0] log_arg [64];
  logic [1:0]  log_kind[64];
  int          log_cyc [64];
  logic [15:0] log_khz [8];
  int          rdy_cyc [8];

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_default();
    cfg_cmd8_ok = 1; cfg_echo_bad = 0; cfg_sd_ok = 1; cfg_mmc_ok = 1; cfg_ccs = 1;
    cfg_busy = 1; cfg_fail_idx = -1; cfg_rca = 16'h1234; volt_mask = 24'hFF8000;
    n_cmd = 0; n_clk = 0; hold_bad = 0; opn = 0;
  endtask

  function automatic int find_cmd(input int idx, input int nth);
    int seen = 0;
    for (int i = 0; i < n_cmd && i < 64; i++)
      if (log_idx[i] == 6'(idx)) begin
        if (seen == nth) return i;
        seen++;
      end
    return -1;
  endfunction

  function automatic int count_cmd(input int idx);
    int c = 0;
    for (int i = 0; i < n_cmd && i < 64; i++) if (log_idx[i] == 6'(idx)) c++;
    return c;
  endfunction

  // command responder
  initial begin
    bit app = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [5:0] i; logic [31:0] a; logic e; logic [127:0] r;
        i = cmd_idx; a = cmd_arg;
        if (n_cmd < 64) begin
          log_idx[n_cmd] = i; log_arg[n_cmd] = a; log_kind[n_cmd] = cmd_rsp; log_cyc[n_cmd] = cyc;
        end
        n_cmd++;
        e = 0; r = '0;
        case (i)
          6'd8:  begin e = !cfg_cmd8_ok; r = {96'h0, cfg_echo_bad ? (a ^ 32'h1) : a}; end
          6'd41: begin opn++; e = !(cfg_sd_ok && app); r = {96'h0, opn > cfg_busy, cfg_ccs, 30'h0}; end
          6'd1:  begin opn++; e = !cfg_mmc_ok; r = {96'h0, opn > cfg_busy, cfg_ccs, 30'h0}; end
          6'd2:  r = CID_PAT;
          6'd3:  r = {96'h0, cfg_rca, 16'h0};
          6'd9:  r = CSD_PAT;
          default: ;
        endcase
        app = (i == 6'd55);
        if (int'(i) == cfg_fail_idx) e = 1;
        repeat (2) begin
          @(negedge clk);
          if (!cmd_valid || cmd_idx != i || cmd_arg != a) hold_bad++;
        end
        cmd_done = 1; cmd_err = e; rsp_data = r;
        @(negedge clk);
        cmd_done = 0; cmd_err = 0;
      end
    end
  end

  // clock generator model
  initial begin
    forever begin
      @(negedge clk);
      if (clk_req) begin
        if (n_clk < 8) log_khz[n_clk] = clk_khz;
        repeat (3) @(negedge clk);
        clk_rdy = 1;
        if (n_clk < 8) rdy_cyc[n_clk] = cyc;
        n_clk++;
        @(negedge clk);
        clk_rdy = 0;
      end
    end
  end

  task automatic run_init();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done || fail) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    // R1
    chk("R1 reset outputs", {done, fail, fail_code, is_mmc, is_hc, rca, cmd_valid, clk_req, clk_khz},
        '0);
  endtask

  task automatic t_sd_hc();
    int p;
    cfg_default(); cfg_busy = 2;
    run_init();
    chk("R2 first clock rate", log_khz[0], 400);
    chk("R2 reset cmd idx/kind/arg", {log_idx[0], log_kind[0], log_arg[0]}, {6'd0, 2'd0, 32'h0});
    chk("R2 settle wait", (log_cyc[0] - rdy_cyc[0]) >= SETTLE, 1);
    chk("R3 if-cond arg upper", {log_idx[1], log_kind[1], log_arg[1]}, {6'd8, 2'd1, 32'h1AA});
    chk("R5 sd probe order", {log_idx[2], log_arg[2], log_idx[3], log_arg[3]}, {6'd55, 32'h0, 6'd41, 32'h0});
    chk("R4 R6 poll arg hcs", {log_idx[4], log_idx[5], log_arg[5]}, {6'd55, 6'd41, 32'h40FF8000});
    chk("R6 poll count", count_cmd(41), 3);
    chk("R6 poll gap", (log_cyc[6] - log_cyc[5]) >= GAP, 1);
    chk("R8 high capacity", {is_hc, is_mmc}, 2'b10);
    p = find_cmd(3, 0);
    chk("R9 sd rca arg", (p >= 0) ? log_arg[p] : 32'hDEAD, 32'h0);
    chk("R9 rca and cid", {rca, cid}, {16'h1234, CID_PAT});
    p = find_cmd(9, 0);
    chk("R10 csd arg/kind", (p >= 0) ? {log_kind[p], log_arg[p]} : '1, {2'd2, 32'h1234_0000});
    p = find_cmd(7, 0);
    chk("R10 select arg/kind", (p >= 0) ? {log_kind[p], log_arg[p]} : '1, {2'd3, 32'h1234_0000});
    chk("R10 csd and fast clock", {csd, log_khz[1]}, {CSD_PAT, 16'd25000});
    chk("R10 done", {done, fail}, 2'b10);
    chk("R12 command hold", hold_bad, 0);
    // R13 results hold while done
    repeat (20) @(negedge clk);
    chk("R13 done holds", {done, rca, cid}, {1'b1, 16'h1234, CID_PAT});
  endtask

  task automatic t_sd_nohc();
    cfg_default(); volt_mask = 24'h000180; cfg_echo_bad = 1; cfg_ccs = 0; cfg_busy = 0;
    run_init();
    chk("R3 if-cond arg lower", log_arg[1], 32'h2AA);
    chk("R4 echo mismatch clears hcs", log_arg[5], 32'h0000_0180);
    chk("R8 standard capacity", {is_hc, done}, 2'b01);
    cfg_default(); cfg_cmd8_ok = 0; cfg_ccs = 1; cfg_busy = 0;
    run_init();
    chk("R4 cmd8 error no fail, hcs clear", {log_arg[5][30], done, is_hc}, 3'b011);
  endtask

  task automatic t_mmc();
    cfg_default(); cfg_sd_ok = 0;
    run_init();
    chk("R5 mmc fallback", {log_idx[4], log_arg[4], is_mmc}, {6'd1, 32'h0, 1'b1});
    chk("R6 mmc poll arg", {log_idx[5], log_arg[5]}, {6'd1, 32'h40FF8000});
    chk("R6 mmc no app after probe", count_cmd(55), 1);
    chk("R9 mmc rca", {log_arg[find_cmd(3, 0)], rca}, {32'h0001_0000, 16'h0001});
    chk("R10 mmc csd arg", log_arg[find_cmd(9, 0)], 32'h0001_0000);
    chk("R10 mmc done", done, 1);
  endtask

  task automatic t_nocard();
    cfg_default(); cfg_sd_ok = 0; cfg_mmc_ok = 0;
    run_init();
    chk("R5 no card fail", {fail, done, fail_code}, {1'b1, 1'b0, 4'd2});
    chk("R5 no cid after fail", count_cmd(2), 0);
    repeat (10) @(negedge clk);
    chk("R13 fail holds", {fail, fail_code}, {1'b1, 4'd2});
  endtask

  task automatic t_timeout();
    cfg_default(); cfg_busy = 1000;
    run_init();
    chk("R7 poll timeout", {fail, fail_code}, {1'b1, 4'd4});
    chk("R7 poll attempts", count_cmd(41), PMAX + 1);
    cfg_default(); cfg_fail_idx = 41; cfg_sd_ok = 1;
    cfg_mmc_ok = 0;
    run_init();
    chk("R5 sd probe error falls back and fails", fail_code, 4'd2);
  endtask

  task automatic t_errors();
    cfg_default(); cfg_fail_idx = 0; run_init();
    chk("R11 reset cmd error", {fail, fail_code}, {1'b1, 4'd1});
    cfg_default(); cfg_fail_idx = 2; run_init();
    chk("R11 cid error", {fail, fail_code}, {1'b1, 4'd5});
    cfg_default(); cfg_fail_idx = 3; run_init();
    chk("R11 rca error", {fail, fail_code}, {1'b1, 4'd6});
    cfg_default(); cfg_fail_idx = 9; run_init();
    chk("R11 csd error", {fail, fail_code}, {1'b1, 4'd7});
    cfg_default(); cfg_fail_idx = 7; run_init();
    chk("R11 select error", {fail, fail_code}, {1'b1, 4'd8});
    cfg_default(); cfg_sd_ok = 0; cfg_busy = 2; cfg_fail_idx = -1; run_init();
    chk("R7 poll recovers mmc", done, 1);
  endtask

  task automatic t_start_busy();
    cfg_default();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int k = 0; k < 5000 && n_cmd < 3; k++) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    chk("R13 start ignored while busy", {count_cmd(0), n_clk, done}, {32'd1, 32'd2, 1'b1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cfg_default();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sd_hc();
    t_sd_nohc();
    t_mmc();
    t_nocard();
    t_timeout();
    t_errors();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule